// File: doc/BRIEF.md
# Transition-Timed Learning Window Generator

This block supplies the timing that a spiking, table-per-synapse Q-learning array needs around each state change. It holds back every action spike train and every state line by one fixed interval, so that the spikes describing the state just left are still present after the move. During that interval they overlap with the spikes describing the state just entered. On each move to a new non-zero state it opens a learning window pulse whose width follows the learning rate. That width is never allowed to exceed the hold-back interval, so updates can only happen while both sets of spikes overlap. It also merges the discounted-maximum spike lines of all actions into a single broadcast line.

Timing is given in milliseconds and converted to clock cycles through a ticks-per-millisecond parameter. All delays and widths are therefore whole cycle counts. A delay line is a plain shift register, so every spike keeps its position and order. The pulse counter restarts with its full width when a new transition arrives while a window is still open.

Top module: `learn_window_gen`

## Requirements
- R1: Each action spike line is delayed on its own by exactly DELAY_TICKS = TD_MS * TICKS_PER_MS cycles: `actSpikeDly[m]` in cycle c equals `actSpikeIn[m]` in cycle c - DELAY_TICKS. It is 0 while fewer than DELAY_TICKS cycles have passed since reset.
- R2: Each bit of `stateIn` is delayed by the same DELAY_TICKS cycles onto `stateDly`. Bit n stands for state n, one-hot.
- R3: A transition is a cycle in which `stateIn` is non-zero and differs from its value in the previous cycle. The value before the first cycle after reset counts as all zeros. `alphaPulse` is 1 in the cycle after a transition.
- R4: After a single transition, `alphaPulse` stays 1 for exactly ALPHA_TICKS = min(TA_MS, TD_MS) * TICKS_PER_MS cycles, and then returns to 0.
- R5: When TA_MS exceeds TD_MS, the pulse width is clamped to DELAY_TICKS cycles.
- R6: A transition that arrives while the pulse is high restarts it. The pulse then lasts a full ALPHA_TICKS cycles counted from the new transition.
- R7: A change of `stateIn` to all zeros, or holding the same value, starts no pulse.
- R8: `gammaBcast` is the OR of all bits of `gammaSpikeIn` in the same cycle.
- R9: While `rstN` is low, `actSpikeDly`, `stateDly` and `alphaPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateIn | input | NUM_STATES | One-hot current state |
| actSpikeIn | input | NUM_ACTIONS | Spike line of each action neuron |
| gammaSpikeIn | input | NUM_ACTIONS | Spike line of each discounted-maximum neuron |
| actSpikeDly | output | NUM_ACTIONS | Delayed action spike lines |
| stateDly | output | NUM_STATES | Delayed state lines |
| gammaBcast | output | 1 | OR of the discounted-maximum lines |
| alphaPulse | output | 1 | Learning window pulse |

## Verification
The bench builds two copies from one shared stimulus, both with four states, two actions and four ticks per millisecond. The first uses TD_MS = 5 and TA_MS = 3, giving a 20-cycle delay and a 12-cycle window. Because the window is shorter than the delay, a check on the pulse width cannot confuse the two parameters. The second uses TD_MS = 2 and TA_MS = 8, where the clamp must cut the window to 8 cycles. This brings the clamp, and a retrigger during a short window, within reach in a few hundred cycles.

// File: rtl/lwin_pkg.sv
package lwin_pkg;

  typedef struct packed {
    logic restart;
  } lwinStrobe_t;

  function automatic int clampTicks(input int want, input int limit);
    return (want > limit) ? limit : want;
  endfunction

  function automatic int cntWidth(input int maxVal);
    return (maxVal > 0) ? $clog2(maxVal + 1) : 1;
  endfunction

endpackage

// File: rtl/lwin_delay_line.sv
module lwin_delay_line #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineIn,
  output logic [WIDTH-1:0] lineOut
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign lineOut = lineIn;
    end else begin : g_shift
      localparam int WARM_W = lwin_pkg::cntWidth(DEPTH);
      logic [WIDTH-1:0] stages [DEPTH];
      logic [WARM_W-1:0] warm;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < DEPTH; i++) stages[i] <= '0;
        end else begin
          stages[0] <= lineIn;
          for (int i = 1; i < DEPTH; i++) stages[i] <= stages[i-1];
        end
      end

      assign lineOut = stages[DEPTH-1];

      // cycles since reset, saturating at DEPTH (checker support)
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) warm <= '0;
        else if (warm != WARM_W'(DEPTH)) warm <= warm + 1'b1;
      end

      // R1/R2: nothing reaches the output before a full delay has elapsed
      a_r1_warmup_quiet: assert property (@(posedge clk) disable iff (!rstN)
        (warm < WARM_W'(DEPTH)) |-> (lineOut == '0));
    end
  endgenerate

endmodule

// File: rtl/lwin_ctrl.sv
module lwin_ctrl
  import lwin_pkg::*;
#(
  parameter int NUM_STATES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_STATES-1:0] stateIn,
  output lwinStrobe_t           strobes
);

  logic [NUM_STATES-1:0] stateReg;
  logic stateLive;
  logic stateMoved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateReg <= '0;
    else       stateReg <= stateIn;
  end

  assign stateLive  = |stateIn;
  assign stateMoved = (stateIn != stateReg);

  always_comb begin
    strobes = '0;
    strobes.restart = stateLive && stateMoved;
  end

  // R3: a restart is always followed by a changed, non-zero remembered state
  a_r3_restart_moves: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> ((stateReg != $past(stateReg)) && (stateReg != '0)));

endmodule

// File: rtl/lwin_datapath.sv
module lwin_datapath
  import lwin_pkg::*;
#(
  parameter int NUM_STATES  = 4,
  parameter int NUM_ACTIONS = 2,
  parameter int DELAY_TICKS = 20,
  parameter int ALPHA_TICKS = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lwinStrobe_t            strobes,
  input  logic [NUM_STATES-1:0]  stateIn,
  input  logic [NUM_ACTIONS-1:0] actSpikeIn,
  input  logic [NUM_ACTIONS-1:0] gammaSpikeIn,
  output logic [NUM_ACTIONS-1:0] actSpikeDly,
  output logic [NUM_STATES-1:0]  stateDly,
  output logic                   gammaBcast,
  output logic                   alphaPulse
);

  localparam int CNT_W = cntWidth(DELAY_TICKS);
  localparam logic [CNT_W-1:0] ALPHA_LOAD = CNT_W'(ALPHA_TICKS);
  localparam logic [CNT_W-1:0] CNT_LIMIT  = CNT_W'(DELAY_TICKS);

  logic [CNT_W-1:0] alphaCnt;

  // one delay line per action neuron
  genvar m;
  generate
    for (m = 0; m < NUM_ACTIONS; m++) begin : g_act
      lwin_delay_line #(.WIDTH(1), .DEPTH(DELAY_TICKS)) actDly_i (
        .clk    (clk),
        .rstN   (rstN),
        .lineIn (actSpikeIn[m]),
        .lineOut(actSpikeDly[m])
      );
    end
  endgenerate

  lwin_delay_line #(.WIDTH(NUM_STATES), .DEPTH(DELAY_TICKS)) stateDly_i (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (stateIn),
    .lineOut(stateDly)
  );

  assign gammaBcast = |gammaSpikeIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 alphaCnt <= '0;
    else if (strobes.restart)  alphaCnt <= ALPHA_LOAD;
    else if (alphaCnt != '0)   alphaCnt <= alphaCnt - 1'b1;
  end

  assign alphaPulse = (alphaCnt != '0);

  // R6: every restart reloads the full window
  a_r6_restart_full: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (alphaCnt == ALPHA_LOAD));

  // R5: the remaining window never exceeds the delay interval
  a_r5_clamp_bound: assert property (@(posedge clk) disable iff (!rstN)
    alphaCnt <= CNT_LIMIT);

endmodule

// File: rtl/learn_window_gen.sv
module learn_window_gen
  import lwin_pkg::*;
#(
  parameter int NUM_STATES   = 4,
  parameter int NUM_ACTIONS  = 2,
  parameter int TICKS_PER_MS = 4,
  parameter int TD_MS        = 5,
  parameter int TA_MS        = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STATES-1:0]  stateIn,
  input  logic [NUM_ACTIONS-1:0] actSpikeIn,
  input  logic [NUM_ACTIONS-1:0] gammaSpikeIn,
  output logic [NUM_ACTIONS-1:0] actSpikeDly,
  output logic [NUM_STATES-1:0]  stateDly,
  output logic                   gammaBcast,
  output logic                   alphaPulse
);

  localparam int DELAY_TICKS = TD_MS * TICKS_PER_MS;
  localparam int ALPHA_REQ   = TA_MS * TICKS_PER_MS;
  localparam int ALPHA_TICKS = clampTicks(ALPHA_REQ, DELAY_TICKS);

  lwinStrobe_t strobes;

  lwin_ctrl #(.NUM_STATES(NUM_STATES)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .stateIn(stateIn),
    .strobes(strobes)
  );

  lwin_datapath #(
    .NUM_STATES (NUM_STATES),
    .NUM_ACTIONS(NUM_ACTIONS),
    .DELAY_TICKS(DELAY_TICKS),
    .ALPHA_TICKS(ALPHA_TICKS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .stateIn     (stateIn),
    .actSpikeIn  (actSpikeIn),
    .gammaSpikeIn(gammaSpikeIn),
    .actSpikeDly (actSpikeDly),
    .stateDly    (stateDly),
    .gammaBcast  (gammaBcast),
    .alphaPulse  (alphaPulse)
  );

  // R4: the window only closes after a cycle without a restart
  a_r4_close_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alphaPulse) |-> !$past(strobes.restart));

endmodule

// File: tb/learn_window_gen_tb_top.sv
`timescale 1ns/1ps
module learn_window_gen_tb_top;

  localparam int NS = 4;
  localparam int NA = 2;
  localparam int TPM = 4;
  localparam int DM = 5 * TPM;   // main delay
  localparam int AM = 3 * TPM;   // main window
  localparam int DC = 2 * TPM;   // clamp copy delay
  localparam int AC = 2 * TPM;   // clamp copy window (TA 8 ms clamped to 2 ms)
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] stateIn = '0;
  logic [NA-1:0] actIn = '0;
  logic [NA-1:0] gamIn = '0;

  logic [NA-1:0] actDlyM, actDlyC;
  logic [NS-1:0] stDlyM, stDlyC;
  logic gamM, gamC, alM, alC;

  always #2 clk = ~clk;

  learn_window_gen #(.NUM_STATES(NS), .NUM_ACTIONS(NA), .TICKS_PER_MS(TPM),
                     .TD_MS(5), .TA_MS(3)) dut_i (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .actSpikeIn(actIn),
    .gammaSpikeIn(gamIn), .actSpikeDly(actDlyM), .stateDly(stDlyM),
    .gammaBcast(gamM), .alphaPulse(alM));

  learn_window_gen #(.NUM_STATES(NS), .NUM_ACTIONS(NA), .TICKS_PER_MS(TPM),
                     .TD_MS(2), .TA_MS(8)) dut_clamp_i (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .actSpikeIn(actIn),
    .gammaSpikeIn(gamIn), .actSpikeDly(actDlyC), .stateDly(stDlyC),
    .gammaBcast(gamC), .alphaPulse(alC));

  typedef struct {
    logic [NA-1:0] actM; logic [NS-1:0] stM; logic alphaM;
    logic [NA-1:0] actC; logic [NS-1:0] stC; logic alphaC;
    logic gamma; string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NA-1:0] actHist [HMAX];
  logic [NS-1:0] stHist [HMAX];
  int cyc = 0;
  logic [NS-1:0] prevState = '0;
  int cntM = 0;
  int cntC = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [NA-1:0] actAt(int idx);
    return (idx < 0) ? '0 : actHist[idx];
  endfunction
  function automatic logic [NS-1:0] stAt(int idx);
    return (idx < 0) ? '0 : stHist[idx];
  endfunction

  task automatic driveCycle(input logic [NS-1:0] st, input string tag);
    expItem_t it;
    bit trans;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stateIn = st;
    actIn = lfsr[1:0] & lfsr[5:4];
    gamIn = lfsr[3:2] & lfsr[9:8];
    actHist[cyc] = actIn;
    stHist[cyc] = st;
    trans = (st != prevState) && (st != '0);
    prevState = st;
    cntM = trans ? AM : ((cntM > 0) ? cntM - 1 : 0);
    cntC = trans ? AC : ((cntC > 0) ? cntC - 1 : 0);
    it.actM = actAt(cyc + 1 - DM);
    it.stM  = stAt(cyc + 1 - DM);
    it.alphaM = (cntM != 0);
    it.actC = actAt(cyc + 1 - DC);
    it.stC  = stAt(cyc + 1 - DC);
    it.alphaC = (cntC != 0);
    it.gamma = |gamIn;
    it.tag = tag;
    expQ.push_back(it);
    cyc++;
  endtask

  task automatic holdState(input logic [NS-1:0] st, input int n, input string tag);
    for (int i = 0; i < n; i++) driveCycle(st, tag);
  endtask

  // monitor: compare once per cycle, 1 ns after the rising edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (actDlyM !== it.actM) begin errors++;
          $display("FAIL R1 main act delay got %b exp %b", actDlyM, it.actM); end
        if (actDlyC !== it.actC) begin errors++;
          $display("FAIL R1 clamp act delay got %b exp %b", actDlyC, it.actC); end
        if (stDlyM !== it.stM) begin errors++;
          $display("FAIL R2 main state delay got %b exp %b", stDlyM, it.stM); end
        if (stDlyC !== it.stC) begin errors++;
          $display("FAIL R2 clamp state delay got %b exp %b", stDlyC, it.stC); end
        if (alM !== it.alphaM) begin errors++;
          $display("FAIL %s main alpha got %b exp %b", it.tag, alM, it.alphaM); end
        if (alC !== it.alphaC) begin errors++;
          $display("FAIL R5 clamp alpha got %b exp %b", alC, it.alphaC); end
        if ((gamM !== it.gamma) || (gamC !== it.gamma)) begin errors++;
          $display("FAIL R8 gamma got %b/%b exp %b", gamM, gamC, it.gamma); end
      end
    end
  end

  // watchdog
  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got running exp done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero during reset even with busy inputs
    stateIn = 4'b0001; actIn = '1; gamIn = '0;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if ((actDlyM !== '0) || (stDlyM !== '0) || (alM !== 1'b0) ||
        (actDlyC !== '0) || (stDlyC !== '0) || (alC !== 1'b0)) begin
      errors++;
      $display("FAIL R9 reset outputs got %b %b %b exp 0 0 0", actDlyM, stDlyM, alM);
    end
    @(negedge clk);
    stateIn = '0; actIn = '0;
    rstN = 1'b1;

    holdState(4'b0000, 3, "R7");      // idle zero: no window
    holdState(4'b0001, 40, "R4");     // first transition, full width
    holdState(4'b0000, 30, "R7");     // drop to zero: no window
    holdState(4'b0001, 30, "R3");     // return from zero counts as transition
    holdState(4'b0010, 5, "R6");      // move, then retrigger inside window
    holdState(4'b0100, 30, "R6");
    holdState(4'b1000, 3, "R6");      // several quick moves
    holdState(4'b0001, 3, "R6");
    holdState(4'b0010, 40, "R6");
    holdState(4'b0010, 30, "R7");     // long hold: no new window
    holdState(4'b0100, 25, "R3");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule